// File: doc/BRIEF.md
# Fused ReLU Requantization Unit

This unit sits on the stream between two convolution layers of an 8-bit symmetric-quantized network. Each cycle it can take one beat of lane-parallel signed accumulator values and clamp negatives to zero. It then rescales each lane with a single per-layer integer multiplier followed by a rounded right shift. The result is a saturated 8-bit activation code for the next layer. The multiply-shift stands in for the dequantize step of the finished layer and the quantize step of the next one. There is no zero point, so an accumulator of zero always becomes code 0.

The multiplier and shift are per layer. They are loaded through a small request/accept handshake before a layer's data arrives. A load request closes the input and waits for the pipeline to empty. It is accepted in a cycle when no sample is in flight, so every sample is scaled with exactly one configuration. The datapath is three register stages: ReLU, multiply, and round/shift/saturate. A single advance enable moves all stages, so output backpressure freezes the whole pipeline without losing or repeating data.

Top module: `relu_requant_unit`

## Requirements
- R1: A lane whose accumulator (signed, lane i on in_data bits [32i+31:32i]) is negative produces output code 0.
- R2: For a non-negative accumulator x, the lane code is min(127, floor((x*M + H) / 2^S)), where M is the loaded unsigned 16-bit multiplier, S is the loaded 6-bit shift, and H = 2^(S-1) when S > 0 and 0 when S = 0.
- R3: Output codes saturate at 127 and are never negative: bit 7 of every 8-bit lane code is always 0.
- R4: A zero accumulator yields code 0 for every M and S.
- R5: A beat accepted at rising edge k (in_valid and in_ready both high) drives out_valid high from edge k+2, provided no stall intervenes. Beats leave in arrival order.
- R6: While out_valid is high and out_ready is low, every stage holds: out_valid stays high, out_data is unchanged, and no beat is lost or duplicated.
- R7: cfg_accept is high exactly when cfg_load is high and no beat is in flight. in_ready is low whenever cfg_load is high, and otherwise equals (not out_valid) or out_ready.
- R8: A configuration accepted at an edge applies to every beat accepted after that edge. Beats already accepted keep the previous configuration.
- R9: After reset, out_valid and cfg_accept are low, in_ready is high, and the active configuration is M = 1, S = 0.
- R10: Lanes are independent. Output lane i occupies out_data bits [8i+7:8i] and depends only on input lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Request to load a new multiplier/shift; held until cfg_accept |
| cfg_mult | input | 16 | Unsigned per-layer multiplier M |
| cfg_shift | input | 6 | Per-layer right shift S |
| cfg_accept | output | 1 | The request is taken at this clock edge |
| in_valid | input | 1 | Accumulator beat is valid |
| in_ready | output | 1 | Unit accepts a beat at this edge |
| in_data | input | 512 | 16 lanes of 32-bit signed accumulators |
| out_valid | output | 1 | Activation beat is valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 128 | 16 lanes of 8-bit activation codes |

## Verification
Several properties are checked on every cycle. No lane code ever exceeds 127. A zero entering the multiply stage stays zero through rounding. A stalled output holds its valid and data. The configuration registers never change while a beat is in flight, and no load is accepted right after a beat is taken. The exact rounding and saturation values, the two-edge latency and the ordering are shown only by the bench's scenarios. So are the handover of scale at a layer boundary and the absence of loss under random backpressure. The bench compares every cycle against a queue-based model.

// File: rtl/relu_rq_pkg.sv
package relu_rq_pkg;
  localparam int RQ_WIDE_W  = 64;
  localparam int RQ_OUT_W   = 8;
  localparam int RQ_SAT_MAX = (1 << (RQ_OUT_W - 1)) - 1;

  // ReLU on a sign-extended accumulator
  function automatic logic [RQ_WIDE_W-1:0] rq_relu(input logic signed [RQ_WIDE_W-1:0] x);
    return (x < 0) ? '0 : RQ_WIDE_W'(x);
  endfunction

  // round half up, then shift right by s
  function automatic logic [RQ_WIDE_W-1:0] rq_round_shift(input logic [RQ_WIDE_W-1:0] p,
                                                          input logic [5:0] s);
    logic [RQ_WIDE_W-1:0] half;
    half = (s == 6'd0) ? '0 : (RQ_WIDE_W'(1) << (s - 6'd1));
    return (p + half) >> s;
  endfunction

  // upper clamp only: input is never negative after ReLU
  function automatic logic [RQ_OUT_W-1:0] rq_sat(input logic [RQ_WIDE_W-1:0] v);
    return (v > RQ_WIDE_W'(RQ_SAT_MAX)) ? RQ_OUT_W'(RQ_SAT_MAX) : v[RQ_OUT_W-1:0];
  endfunction
endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl #(
  parameter int MULT_W  = 16,
  parameter int SHIFT_W = 6,
  parameter int STAGES  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  output logic               out_valid,
  input  logic               out_ready,
  input  logic               cfg_load,
  input  logic [MULT_W-1:0]  cfg_mult,
  input  logic [SHIFT_W-1:0] cfg_shift,
  output logic               cfg_accept,
  output logic [MULT_W-1:0]  mult_q,
  output logic [SHIFT_W-1:0] shift_q,
  output logic               adv
);
  logic [STAGES-1:0] v_q;
  logic              pipe_empty;
  logic              in_fire;

  assign adv        = !v_q[STAGES-1] || out_ready;
  assign pipe_empty = (v_q == '0);
  assign in_ready   = adv && !cfg_load;
  assign in_fire    = in_valid && in_ready;
  assign cfg_accept = cfg_load && pipe_empty;
  assign out_valid  = v_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (adv) begin
      v_q <= {v_q[STAGES-2:0], in_fire};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q  <= MULT_W'(1);
      shift_q <= '0;
    end else if (cfg_accept) begin
      mult_q  <= cfg_mult;
      shift_q <= cfg_shift;
    end
  end

  // R6: a stalled beat stays presented
  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R7: a beat just taken blocks a load in the following cycle
  p_no_load_after_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> !cfg_accept);

  // R8: scale is frozen while anything is in flight
  p_cfg_frozen_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_empty |=> $stable(mult_q) && $stable(shift_q));
endmodule

// File: rtl/rq_lane.sv
module rq_lane
  import relu_rq_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int MULT_W  = 16,
  parameter int SHIFT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic [ACC_W-1:0]    acc_i,
  input  logic [MULT_W-1:0]   mult_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [RQ_OUT_W-1:0] code_o
);
  localparam int MAG_W = ACC_W - 1;

  logic signed [RQ_WIDE_W-1:0] acc_ext;
  logic [RQ_WIDE_W-1:0]        relu_w;
  logic [MAG_W-1:0]            mag_q;
  logic [RQ_WIDE_W-1:0]        prod_q;
  logic [RQ_OUT_W-1:0]         code_q;
  logic                        mag_is_zero;
  logic                        prod_is_zero;

  assign acc_ext      = {{(RQ_WIDE_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
  assign relu_w       = rq_relu(acc_ext);
  assign mag_is_zero  = (mag_q == '0);
  assign prod_is_zero = (prod_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      prod_q <= '0;
      code_q <= '0;
    end else if (adv) begin
      mag_q  <= relu_w[MAG_W-1:0];
      prod_q <= RQ_WIDE_W'(mag_q) * RQ_WIDE_W'(mult_i);
      code_q <= rq_sat(rq_round_shift(prod_q, 6'(shift_i)));
    end
  end

  assign code_o = code_q;

  // R3: code stays inside the positive range
  p_code_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= RQ_OUT_W'(RQ_SAT_MAX));

  // R4: zero magnitude gives a zero product
  p_zero_mag_to_prod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && mag_is_zero |=> prod_is_zero);

  // R4: rounding never lifts a zero product
  p_zero_prod_to_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && prod_is_zero |=> code_q == '0);
endmodule

// File: rtl/relu_requant_unit.sv
module relu_requant_unit
  import relu_rq_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int ACC_W   = 32,
  parameter int MULT_W  = 16,
  parameter int SHIFT_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_load,
  input  logic [MULT_W-1:0]         cfg_mult,
  input  logic [SHIFT_W-1:0]        cfg_shift,
  output logic                      cfg_accept,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*ACC_W-1:0]    in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*RQ_OUT_W-1:0] out_data
);
  logic               adv;
  logic [MULT_W-1:0]  mult_q;
  logic [SHIFT_W-1:0] shift_q;

  rq_ctrl #(.MULT_W(MULT_W), .SHIFT_W(SHIFT_W), .STAGES(3)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .cfg_load(cfg_load), .cfg_mult(cfg_mult), .cfg_shift(cfg_shift),
    .cfg_accept(cfg_accept), .mult_q(mult_q), .shift_q(shift_q), .adv(adv)
  );

  // R10: one independent datapath per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rq_lane #(.ACC_W(ACC_W), .MULT_W(MULT_W), .SHIFT_W(SHIFT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .acc_i(in_data[g*ACC_W +: ACC_W]),
      .mult_i(mult_q), .shift_i(shift_q),
      .code_o(out_data[g*RQ_OUT_W +: RQ_OUT_W])
    );
  end

  // R6: presented data does not change under a stall
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));
endmodule

// File: tb/tb_relu_requant_unit.sv
module tb_relu_requant_unit;
  localparam int LANES = 16;
  localparam int ACC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [15:0] cfg_mult = '0;
  logic [5:0] cfg_shift = '0;
  logic cfg_accept;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*ACC_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [LANES*8-1:0] out_data;

  always #4 clk = ~clk;

  relu_requant_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mult(cfg_mult),
    .cfg_shift(cfg_shift), .cfg_accept(cfg_accept), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct {
    logic [LANES*ACC_W-1:0] x;
    logic [LANES*8-1:0]     y;
    int                     cnt;
  } ent_t;

  ent_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cur_m = 1;
  int cur_s = 0;

  function automatic int ref_code(longint x, int m, int s);
    logic [63:0] p;
    if (x <= 0) return 0;
    p = 64'(x) * 64'(m);
    if (s > 0) p = p + (64'd1 << (s - 1));
    p = p >> s;
    return (p > 64'd127) ? 127 : int'(p);
  endfunction

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 6))
      0: return -32'($urandom_range(1, 1000000));
      1: return 32'd0;
      2: return 32'($urandom_range(1, 300));
      3: return $urandom & 32'h7fff_ffff;
      4: return 32'h8000_0000;
      5: return 32'h7fff_ffff;
      default: return 32'($urandom_range(1, 70000));
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, settle, compare, advance model
  task automatic cycle(input int vp, input int rp, input bit want_load,
                       input int lm, input int ls, output bit accepted);
    bit exp_ov, adv, exp_ir, exp_acc;
    ent_t e;
    @(negedge clk);
    in_valid  = ($urandom_range(0, 99) < vp);
    out_ready = ($urandom_range(0, 99) < rp);
    cfg_load  = want_load;
    cfg_mult  = 16'(lm);
    cfg_shift = 6'(ls);
    for (int i = 0; i < LANES; i++) in_data[i*ACC_W +: ACC_W] = pick_val();
    #1;
    exp_ov  = (q.size() > 0) && (q[0].cnt == 3);
    adv     = !exp_ov || out_ready;
    exp_acc = cfg_load && (q.size() == 0);
    exp_ir  = adv && !cfg_load;
    chk(out_valid == exp_ov, "R5", "out_valid", longint'(out_valid), longint'(exp_ov));
    chk(in_ready == exp_ir, "R7", "in_ready", longint'(in_ready), longint'(exp_ir));
    chk(cfg_accept == exp_acc, "R7", "cfg_accept", longint'(cfg_accept), longint'(exp_acc));
    if (exp_ov && out_valid) begin
      for (int i = 0; i < LANES; i++) begin
        longint xv, yv, av;
        string tag;
        xv = longint'($signed(q[0].x[i*ACC_W +: ACC_W]));
        yv = longint'(q[0].y[i*8 +: 8]);
        av = longint'(out_data[i*8 +: 8]);
        if (xv < 0) tag = "R1";
        else if (xv == 0) tag = "R4";
        else if (yv == 127) tag = "R3";
        else tag = "R2";
        // R8 config of this beat, R10 lane position
        chk(av == yv, tag, $sformatf("lane %0d code (R8 R10)", i), av, yv);
      end
    end
    if (exp_ov && out_ready) void'(q.pop_front());
    if (adv) foreach (q[i]) if (q[i].cnt < 3) q[i].cnt++;
    if (in_valid && exp_ir) begin
      e.x = in_data;
      e.cnt = 1;
      for (int i = 0; i < LANES; i++)
        e.y[i*8 +: 8] = 8'(ref_code(longint'($signed(in_data[i*ACC_W +: ACC_W])), cur_m, cur_s));
      q.push_back(e);
    end
    accepted = exp_acc;
    if (exp_acc) begin
      cur_m = lm;
      cur_s = ls;
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    int pm[8] = '{1, 3, 32768, 65535, 200, 1, 0, 700};
    int ps[8] = '{0, 2, 20, 63, 8, 1, 5, 12};
    int pv[8] = '{90, 100, 60, 80, 40, 100, 70, 85};
    int pr[8] = '{100, 100, 50, 30, 80, 60, 100, 20};
    bit acc;
    bit want;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
    chk(cfg_accept == 1'b0, "R9", "cfg_accept after reset", longint'(cfg_accept), 0);
    // phase 0 uses the reset scale (R9); later phases load mid-traffic (R7, R8)
    for (int p = 0; p < 8; p++) begin
      want = (p != 0);
      for (int c = 0; c < 300; c++) begin
        cycle(pv[p], pr[p], want, pm[p], ps[p], acc);
        if (acc) want = 1'b0;
      end
      chk(!want, "R7", "load accepted in phase", longint'(want), 0);
    end
    for (int c = 0; c < 20; c++) cycle(0, 100, 1'b0, 0, 0, acc);
    // R6: every accepted beat has left
    chk(q.size() == 0, "R6", "beats left after drain", longint'(q.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule